// File: doc/BRIEF.md
# Packetized Data Port Sequencer

This block moves one flash page between a 32-bit word port on the host side and a byte stream on the flash side. The page is cut into equal packets. Software first writes a packet register that holds both the packet size in bytes and the number of packets. It then writes a start register whose single set bit picks the direction: a page read or a page program.

In a read, the block accepts bytes from the flash stream into a one-packet buffer. Once a whole packet is held, it raises a read-ready flag and the host drains the packet as 32-bit words. In a program, the block raises a write-ready flag, takes one packet of words from the host, and then sends its bytes out on the flash stream. In both directions the cycle repeats once per packet. After the last packet a sticky transfer-complete flag is raised. Small single-packet transfers, such as an 8-byte identifier or a status byte, use a packet count of one.

Top module: `pkt_port_seq`

## Requirements
- R1: The packet register takes the packet size in bits [11:0] and the packet count in bits [12 +: CNT_W] of `cfg_wdata`. It is loaded only while no operation runs; a write during an operation has no effect on that operation.
- R2: A start write is accepted only when the block is idle and the stored size is between 1 and MAX_PKT_BYTES and the stored count is at least 1. Exactly one of bit 0 (page read) and bit 4 (page program) of `start_wdata` must be set. Any other start write is ignored.
- R3: In a read, `fl_in_ready` is high while a packet is being filled. `rd_ready` rises once per packet, after the size-th byte of that packet has been accepted.
- R4: Read words are packed little-endian: packet byte k appears at bits [8*(k mod 4) +: 8] of word k/4. `dp_rdata` carries the word in the cycle after the `dp_rd` strobe.
- R5: A packet takes ceil(size/4) word accesses. In a read, the unused bytes of the last word read as zero. In a program, they are not sent to the flash side.
- R6: In a program, `wr_ready` is high while the block accepts ceil(size/4) words of a packet. The packet's bytes are then sent on `fl_out_data` in packing order, lowest byte of word 0 first.
- R7: While `fl_out_valid` is high and `fl_out_ready` is low, `fl_out_valid` stays high and `fl_out_data` stays stable.
- R8: `xfer_done` rises only when the last word or byte of the last packet has moved. It stays high until the next accepted start, and it is low after reset.
- R9: A `dp_rd` while `rd_ready` is low returns zero and does not advance the word pointer. A `dp_wr` while `wr_ready` is low is dropped and does not advance the pointer.
- R10: At most one of `rd_ready`, `wr_ready`, `fl_in_ready` and `fl_out_valid` is high at any time, and all four are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the packet register |
| cfg_wdata | input | 32 | Packet size and count |
| start_we | input | 1 | Write strobe for the start register |
| start_wdata | input | 32 | One-hot start: bit 0 read, bit 4 program |
| dp_rd | input | 1 | Data port read strobe |
| dp_rdata | output | 32 | Data port read word, valid the cycle after `dp_rd` |
| dp_wr | input | 1 | Data port write strobe |
| dp_wdata | input | 32 | Data port write word |
| rd_ready | output | 1 | A full read packet is available |
| wr_ready | output | 1 | A write packet can be accepted |
| xfer_done | output | 1 | Last packet moved (sticky) |
| fl_in_valid | input | 1 | Flash-side byte valid (read) |
| fl_in_data | input | 8 | Flash-side byte (read) |
| fl_in_ready | output | 1 | Block accepts a flash byte |
| fl_out_valid | output | 1 | Byte to flash valid (program) |
| fl_out_data | output | 8 | Byte to flash (program) |
| fl_out_ready | input | 1 | Flash side accepts the byte |

## Verification
The assertions assume that the host and the flash side keep to the handshakes. `fl_in_valid` and `dp_rd`/`dp_wr` are only meaningful against the current ready flags. The flash side may stall `fl_out_ready` at any time, and the byte hold property relies on that. The directed stimulus drives each strobe for exactly one cycle per intended transfer and drives inputs one time unit after the clock edge. It stalls the outgoing byte stream in a fixed pattern. It issues the deliberately illegal port accesses and start codes only at points where the requirements define the result.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;
  localparam int CNT_LSB      = 12;  // packet count starts here; size occupies the bits below
  localparam int START_RD_BIT = 0;
  localparam int START_WR_BIT = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FILL,
    ST_RD_DRAIN,
    ST_WR_FILL,
    ST_WR_LOAD,
    ST_WR_SEND
  } seq_state_t;
endpackage

// File: rtl/pkt_cfg.sv
module pkt_cfg
  import pkt_seq_pkg::*;
#(
  parameter int MAX_PKT_BYTES = 64,
  parameter int CNT_W         = 12,
  localparam int SZ_W         = CNT_LSB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic                idle,
  input  logic [SZ_W-1:0]     size_in,
  input  logic [CNT_W-1:0]    cnt_in,
  output logic [SZ_W-1:0]     pkt_size,
  output logic [CNT_W-1:0]    pkt_cnt,
  output logic [SZ_W-1:0]     pkt_words,
  output logic                cfg_ok
);
  logic [SZ_W:0] words_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_size <= '0;
      pkt_cnt  <= '0;
    end else if (we && idle) begin
      pkt_size <= size_in;
      pkt_cnt  <= cnt_in;
    end
  end

  // word accesses per packet, rounded up
  assign words_ext = ({1'b0, pkt_size} + (SZ_W+1)'(3)) >> 2;
  assign pkt_words = words_ext[SZ_W-1:0];
  assign cfg_ok    = (pkt_size != '0) && (pkt_size <= SZ_W'(MAX_PKT_BYTES)) && (pkt_cnt != '0);
endmodule

// File: rtl/pkt_buf.sv
module pkt_buf #(
  parameter int WORDS = 16,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pkt_ctrl.sv
module pkt_ctrl
  import pkt_seq_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int AW       = 4,
  localparam int SZ_W    = CNT_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic [SZ_W-1:0]  pkt_size,
  input  logic [CNT_W-1:0] pkt_cnt,
  input  logic [SZ_W-1:0]  pkt_words,
  input  logic             cfg_ok,
  input  logic             dp_rd,
  input  logic             dp_wr,
  input  logic [31:0]      dp_wdata,
  input  logic             fl_in_valid,
  input  logic [7:0]       fl_in_data,
  input  logic             fl_out_ready,
  input  logic [31:0]      buf_rdata,
  output seq_state_t       state,
  output logic             rd_ready,
  output logic             wr_ready,
  output logic             xfer_done,
  output logic             fl_in_ready,
  output logic             fl_out_valid,
  output logic [7:0]       fl_out_data,
  output logic             rd_zero,
  output logic             buf_we,
  output logic [AW-1:0]    buf_waddr,
  output logic [31:0]      buf_wdata,
  output logic             buf_re,
  output logic [AW-1:0]    buf_raddr
);
  seq_state_t       st;
  logic [SZ_W-1:0]  bcnt;
  logic [AW-1:0]    wptr;
  logic [CNT_W-1:0] pidx;
  logic [31:0]      asm_q, merged;
  logic             in_fire, last_byte, last_word, last_pkt, lane_end;

  assign state        = st;
  assign fl_in_ready  = (st == ST_RD_FILL);
  assign rd_ready     = (st == ST_RD_DRAIN);
  assign wr_ready     = (st == ST_WR_FILL);
  assign fl_out_valid = (st == ST_WR_SEND);
  assign fl_out_data  = buf_rdata[{bcnt[1:0], 3'b000} +: 8];

  assign in_fire   = fl_in_valid && fl_in_ready;
  assign last_byte = (bcnt == pkt_size - 1'b1);
  assign last_word = ({{(SZ_W-AW){1'b0}}, wptr} == pkt_words - 1'b1);
  assign last_pkt  = (pidx == pkt_cnt - 1'b1);
  assign lane_end  = (bcnt[1:0] == 2'd3);

  always_comb begin
    merged = asm_q;
    merged[{bcnt[1:0], 3'b000} +: 8] = fl_in_data;
  end

  // buffer ports: the fill side writes, the drain side reads
  always_comb begin
    if (st == ST_RD_FILL) begin
      buf_we    = in_fire && (lane_end || last_byte);
      buf_waddr = bcnt[AW+1:2];
      buf_wdata = merged;
    end else begin
      buf_we    = (st == ST_WR_FILL) && dp_wr;
      buf_waddr = wptr;
      buf_wdata = dp_wdata;
    end
    buf_re    = ((st == ST_RD_DRAIN) && dp_rd) || (st == ST_WR_LOAD);
    buf_raddr = (st == ST_RD_DRAIN) ? wptr : bcnt[AW+1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bcnt      <= '0;
      wptr      <= '0;
      pidx      <= '0;
      asm_q     <= '0;
      xfer_done <= 1'b0;
      rd_zero   <= 1'b1;
    end else begin
      if (dp_rd) rd_zero <= (st != ST_RD_DRAIN);
      case (st)
        ST_IDLE: begin
          if (cfg_ok && (start_rd || start_wr)) begin
            st        <= start_rd ? ST_RD_FILL : ST_WR_FILL;
            bcnt      <= '0;
            pidx      <= '0;
            asm_q     <= '0;
            xfer_done <= 1'b0;
          end
        end
        ST_RD_FILL: begin
          if (in_fire) begin
            asm_q <= (lane_end || last_byte) ? '0 : merged;
            if (last_byte) begin
              bcnt <= '0;
              st   <= ST_RD_DRAIN;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        ST_RD_DRAIN: begin
          if (dp_rd) begin
            if (last_word) begin
              wptr <= '0;
              if (last_pkt) begin
                st        <= ST_IDLE;
                xfer_done <= 1'b1;
              end else begin
                pidx <= pidx + 1'b1;
                st   <= ST_RD_FILL;
              end
            end else begin
              wptr <= wptr + 1'b1;
            end
          end
        end
        ST_WR_FILL: begin
          if (dp_wr) begin
            if (last_word) begin
              wptr <= '0;
              st   <= ST_WR_LOAD;
            end else begin
              wptr <= wptr + 1'b1;
            end
          end
        end
        ST_WR_LOAD: st <= ST_WR_SEND;
        ST_WR_SEND: begin
          if (fl_out_ready) begin
            if (last_byte) begin
              bcnt <= '0;
              if (last_pkt) begin
                st        <= ST_IDLE;
                xfer_done <= 1'b1;
              end else begin
                pidx <= pidx + 1'b1;
                st   <= ST_WR_FILL;
              end
            end else begin
              bcnt <= bcnt + 1'b1;
              if (lane_end) st <= ST_WR_LOAD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_port_seq.sv
module pkt_port_seq
  import pkt_seq_pkg::*;
#(
  parameter int MAX_PKT_BYTES = 64,
  parameter int CNT_W         = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        start_we,
  input  logic [31:0] start_wdata,
  input  logic        dp_rd,
  output logic [31:0] dp_rdata,
  input  logic        dp_wr,
  input  logic [31:0] dp_wdata,
  output logic        rd_ready,
  output logic        wr_ready,
  output logic        xfer_done,
  input  logic        fl_in_valid,
  input  logic [7:0]  fl_in_data,
  output logic        fl_in_ready,
  output logic        fl_out_valid,
  output logic [7:0]  fl_out_data,
  input  logic        fl_out_ready
);
  localparam int SZ_W      = CNT_LSB;
  localparam int BUF_WORDS = MAX_PKT_BYTES / 4;
  localparam int AW        = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  logic [SZ_W-1:0]  pkt_size, pkt_words;
  logic [CNT_W-1:0] pkt_cnt;
  logic             cfg_ok, seq_idle, rd_zero;
  logic             start_rd, start_wr;
  logic             buf_we, buf_re;
  logic [AW-1:0]    buf_waddr, buf_raddr;
  logic [31:0]      buf_wdata, buf_rdata;
  seq_state_t       state;
  logic             unused_bits;

  assign unused_bits = ^{cfg_wdata, start_wdata};
  assign seq_idle    = (state == ST_IDLE);
  assign start_rd    = start_we &&  start_wdata[START_RD_BIT] && !start_wdata[START_WR_BIT];
  assign start_wr    = start_we && !start_wdata[START_RD_BIT] &&  start_wdata[START_WR_BIT];
  assign dp_rdata    = rd_zero ? 32'h0 : buf_rdata;

  pkt_cfg #(.MAX_PKT_BYTES(MAX_PKT_BYTES), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .idle(seq_idle),
    .size_in(cfg_wdata[SZ_W-1:0]), .cnt_in(cfg_wdata[CNT_LSB +: CNT_W]),
    .pkt_size(pkt_size), .pkt_cnt(pkt_cnt), .pkt_words(pkt_words), .cfg_ok(cfg_ok)
  );

  pkt_buf #(.WORDS(BUF_WORDS)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .re(buf_re), .raddr(buf_raddr), .rdata(buf_rdata)
  );

  pkt_ctrl #(.CNT_W(CNT_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start_rd(start_rd), .start_wr(start_wr),
    .pkt_size(pkt_size), .pkt_cnt(pkt_cnt), .pkt_words(pkt_words), .cfg_ok(cfg_ok),
    .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .fl_in_valid(fl_in_valid), .fl_in_data(fl_in_data), .fl_out_ready(fl_out_ready),
    .buf_rdata(buf_rdata), .state(state),
    .rd_ready(rd_ready), .wr_ready(wr_ready), .xfer_done(xfer_done),
    .fl_in_ready(fl_in_ready), .fl_out_valid(fl_out_valid), .fl_out_data(fl_out_data),
    .rd_zero(rd_zero), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_re(buf_re), .buf_raddr(buf_raddr)
  );
endmodule

// File: rtl/pkt_port_seq_chk.sv
module pkt_port_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        idle,
  input logic        start_we,
  input logic [31:0] start_wdata,
  input logic        dp_rd,
  input logic [31:0] dp_rdata,
  input logic        rd_ready,
  input logic        wr_ready,
  input logic        xfer_done,
  input logic        fl_in_ready,
  input logic        fl_out_valid,
  input logic [7:0]  fl_out_data,
  input logic        fl_out_ready
);
  a_r10_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_ready, wr_ready, fl_in_ready, fl_out_valid}));

  a_r2_both_bits_ignored: assert property (@(posedge clk) disable iff (rst)
    idle && start_we && start_wdata[0] && start_wdata[4] |=> !fl_in_ready && !wr_ready);

  a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
    fl_out_valid && !fl_out_ready |=> fl_out_valid && $stable(fl_out_data));

  a_r8_done_after_last_move: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_done) |-> $past(rd_ready || fl_out_valid));

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> !rd_ready && !wr_ready && !fl_in_ready && !fl_out_valid);

  a_r9_read_not_ready_zero: assert property (@(posedge clk) disable iff (rst)
    dp_rd && !rd_ready |=> dp_rdata == 32'h0);
endmodule

bind pkt_port_seq pkt_port_seq_chk u_chk (
  .clk(clk), .rst(rst), .idle(seq_idle), .start_we(start_we), .start_wdata(start_wdata),
  .dp_rd(dp_rd), .dp_rdata(dp_rdata), .rd_ready(rd_ready), .wr_ready(wr_ready),
  .xfer_done(xfer_done), .fl_in_ready(fl_in_ready), .fl_out_valid(fl_out_valid),
  .fl_out_data(fl_out_data), .fl_out_ready(fl_out_ready)
);

// File: tb/pkt_port_seq_test.sv
`timescale 1ns/1ps
module pkt_port_seq_test;
  localparam int MAXB = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, start_we = 1'b0, dp_rd = 1'b0, dp_wr = 1'b0;
  logic [31:0] cfg_wdata = '0, start_wdata = '0, dp_wdata = '0;
  logic        fl_in_valid = 1'b0, fl_out_ready = 1'b0;
  logic [7:0]  fl_in_data = '0;
  logic [31:0] dp_rdata;
  logic        rd_ready, wr_ready, xfer_done, fl_in_ready, fl_out_valid;
  logic [7:0]  fl_out_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pkt_port_seq #(.MAX_PKT_BYTES(MAXB), .CNT_W(12)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start_we(start_we), .start_wdata(start_wdata),
    .dp_rd(dp_rd), .dp_rdata(dp_rdata), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .rd_ready(rd_ready), .wr_ready(wr_ready), .xfer_done(xfer_done),
    .fl_in_valid(fl_in_valid), .fl_in_data(fl_in_data), .fl_in_ready(fl_in_ready),
    .fl_out_valid(fl_out_valid), .fl_out_data(fl_out_data), .fl_out_ready(fl_out_ready)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bv(input int seed, input int k);
    return 8'(seed + k * 37 + (k >> 2));
  endfunction

  function automatic logic [31:0] exp_word(input int seed, input int base, input int size, input int w);
    logic [31:0] e = '0;
    for (int b = 0; b < 4; b++)
      if (4 * w + b < size) e[8*b +: 8] = bv(seed, base + 4 * w + b);
    return e;
  endfunction

  task automatic set_cfg(input int size, input int cnt);
    cfg_wdata = (cnt << 12) | size;
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic do_start(input logic [31:0] v);
    start_wdata = v;
    start_we = 1'b1;
    tick();
    start_we = 1'b0;
  endtask

  task automatic push_pkt(input int seed, input int base, input int size);
    for (int k = 0; k < size; k++) begin
      fl_in_valid = 1'b1;
      fl_in_data  = bv(seed, base + k);
      tick();
    end
    fl_in_valid = 1'b0;
  endtask

  task automatic pull_pkt(input int seed, input int base, input int size);
    for (int w = 0; w < (size + 3) / 4; w++) begin
      dp_rd = 1'b1;
      tick();
      dp_rd = 1'b0;
      chk(dp_rdata == exp_word(seed, base, size, w), "R4/R5 read word", dp_rdata, exp_word(seed, base, size, w));
    end
  endtask

  task automatic test_reset();
    chk(!rd_ready && !wr_ready && !fl_in_ready && !fl_out_valid, "R10 flags after reset",
        {rd_ready, wr_ready, fl_in_ready, fl_out_valid}, 0);
    chk(xfer_done == 1'b0, "R8 done after reset", xfer_done, 0);
  endtask

  task automatic test_read(input int size, input int cnt, input int seed, input bit early_rd);
    set_cfg(size, cnt);
    do_start(32'h1);
    chk(fl_in_ready == 1'b1, "R3 fill after start", fl_in_ready, 1);
    chk(xfer_done == 1'b0, "R8 done cleared by start", xfer_done, 0);
    if (early_rd) begin
      dp_rd = 1'b1;
      tick();
      dp_rd = 1'b0;
      chk(dp_rdata == 32'h0, "R9 read while not ready", dp_rdata, 0);
    end
    for (int p = 0; p < cnt; p++) begin
      chk(rd_ready == 1'b0, "R3 not ready before fill", rd_ready, 0);
      push_pkt(seed, p * size, size);
      chk(rd_ready == 1'b1, "R3 ready after full packet", rd_ready, 1);
      chk(!wr_ready && !fl_out_valid && !fl_in_ready, "R10 single flag in read",
          {wr_ready, fl_out_valid, fl_in_ready}, 0);
      pull_pkt(seed, p * size, size);
      if (p < cnt - 1) chk(xfer_done == 1'b0, "R8 done before last packet", xfer_done, 0);
    end
    chk(xfer_done == 1'b1, "R8 done after last packet", xfer_done, 1);
    chk(rd_ready == 1'b0, "R3 ready low after drain", rd_ready, 0);
  endtask

  task automatic test_write(input int size, input int cnt, input int seed, input bit poke);
    set_cfg(size, cnt);
    do_start(32'h10);
    chk(xfer_done == 1'b0, "R8 done cleared by start", xfer_done, 0);
    for (int p = 0; p < cnt; p++) begin
      int got = 0;
      int guard = 0;
      chk(wr_ready == 1'b1, "R6 write ready", wr_ready, 1);
      for (int w = 0; w < (size + 3) / 4; w++) begin
        logic [31:0] wv = exp_word(seed, p * size, size, w);
        for (int b = 0; b < 4; b++) if (4 * w + b >= size) wv[8*b +: 8] = 8'hEE;
        dp_wr = 1'b1;
        dp_wdata = wv;
        tick();
      end
      dp_wr = 1'b0;
      chk(wr_ready == 1'b0, "R6 ready low after packet", wr_ready, 0);
      while (got < size && guard < 400) begin
        logic rdy, v;
        logic [7:0] d;
        rdy = (guard % 3) != 1;
        fl_out_ready = rdy;
        if (poke && guard == 2) begin
          dp_wr = 1'b1;
          dp_wdata = 32'hDEADBEEF;
        end
        v = fl_out_valid;
        d = fl_out_data;
        tick();
        dp_wr = 1'b0;
        if (v && rdy) begin
          chk(d == bv(seed, p * size + got), "R5/R6 byte order", d, bv(seed, p * size + got));
          got++;
        end else if (v) begin
          chk(fl_out_valid && fl_out_data == d, "R7 hold under stall", fl_out_data, d);
        end
        guard++;
      end
      fl_out_ready = 1'b0;
      chk(got == size, "R5 byte count", got, size);
      if (p < cnt - 1) chk(xfer_done == 1'b0, "R8 done before last packet", xfer_done, 0);
    end
    tick();
    chk(fl_out_valid == 1'b0, "R5 no extra bytes", fl_out_valid, 0);
    chk(xfer_done == 1'b1, "R8 done after program", xfer_done, 1);
  endtask

  task automatic test_bad_start();
    set_cfg(8, 1);
    do_start(32'h11);
    tick();
    chk(!fl_in_ready && !wr_ready, "R2 both bits ignored", {fl_in_ready, wr_ready}, 0);
    do_start(32'h4);
    tick();
    chk(!fl_in_ready && !wr_ready, "R2 no start bit ignored", {fl_in_ready, wr_ready}, 0);
    set_cfg(8, 0);
    do_start(32'h1);
    chk(fl_in_ready == 1'b0, "R2 zero count ignored", fl_in_ready, 0);
    set_cfg(0, 1);
    do_start(32'h10);
    chk(wr_ready == 1'b0, "R2 zero size ignored", wr_ready, 0);
    set_cfg(MAXB + 4, 1);
    do_start(32'h1);
    chk(fl_in_ready == 1'b0, "R2 oversize ignored", fl_in_ready, 0);
  endtask

  task automatic test_cfg_busy();
    set_cfg(4, 1);
    do_start(32'h1);
    set_cfg(8, 3);
    push_pkt(9, 0, 4);
    chk(rd_ready == 1'b1, "R1 size kept while busy", rd_ready, 1);
    pull_pkt(9, 0, 4);
    chk(xfer_done == 1'b1, "R1 count kept while busy", xfer_done, 1);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    test_reset();
    test_read(8, 2, 3, 1'b0);
    test_read(6, 1, 5, 1'b1);
    test_read(8, 1, 11, 1'b0);
    test_write(8, 2, 7, 1'b1);
    test_write(5, 1, 13, 1'b0);
    test_bad_start();
    test_cfg_busy();
    repeat (2) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule